// File: doc/BRIEF.md
# Table-Lookup Branch and Return Unit

This unit computes the next instruction address for four control transfers. Two of them fetch their target from memory. A call-table call indexes a halfword table through a 6-bit index and a table base register. A switch jump indexes a halfword table placed right after the current instruction, using a register value as the index. The other two transfers restore saved state: a return from a call-table call, and a return from an exception.

The table-driven operations run in two phases. When the unit accepts the operation it issues one halfword read, holding the request and the address steady. When read-valid arrives it produces the new PC and a one-cycle done strobe. The return operations need no memory access and complete one cycle after they are accepted.

The unit holds the call-table saved PC and saved status. The exception save pairs arrive as inputs, and two bits of the current status word select which pair an exception return uses.

Top module: `tbl_xfer_unit`

## Requirements
- R1: When the unit accepts a call-table call (op_code 0), it stores cur_pc + 2 into saved_pc and status_in into saved_status at the accepting edge.
- R2: A call-table call reads from address (tbase with bit 0 cleared) + (call_idx × 2).
- R3: A call-table call completes with next_pc = (tbase with bit 0 cleared) + (read halfword with bit 0 cleared, zero-extended). done rises in the cycle after the edge that samples mem_valid, and busy falls at that same edge.
- R4: A switch jump (op_code 1) reads from address cur_pc + 2 + (sw_idx × 2), modulo 2^32.
- R5: A switch jump completes with next_pc = cur_pc + 2 + (sign-extended read halfword × 2).
- R6: A call-table return (op_code 2) gives next_pc = saved_pc with bit 0 cleared, and new_status = saved_status AND the writable mask (default 0x000000FF).
- R7: An exception return (op_code 3) with status_in bit 6 set restores next_pc from epc_in and new_status from estat_in. This holds whatever the value of bit 7.
- R8: An exception return with bit 6 clear and bit 7 set restores from fepc_in and fstat_in. With both bits clear it restores from epc_in and estat_in.
- R9: Every restored PC (status_load high) has bit 0 equal to zero.
- R10: While a read is outstanding, busy and mem_req stay high and mem_addr stays stable. Any op_valid in that time is ignored: done stays low and saved_pc and saved_status do not change.
- R11: A return operation raises done and status_load for exactly the one cycle after it is accepted, and raises neither busy nor mem_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | 0 call-table call, 1 switch jump, 2 call-table return, 3 exception return |
| cur_pc | input | 32 | Address of the current instruction |
| tbase | input | 32 | Call-table base register |
| call_idx | input | 6 | Call-table index |
| sw_idx | input | 32 | Switch index register value |
| status_in | input | 32 | Current status word |
| epc_in | input | 32 | Normal exception saved PC |
| estat_in | input | 32 | Normal exception saved status |
| fepc_in | input | 32 | Fatal/NMI saved PC |
| fstat_in | input | 32 | Fatal/NMI saved status |
| mem_req | output | 1 | Halfword read request |
| mem_addr | output | 32 | Read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read halfword |
| busy | output | 1 | Read outstanding |
| done | output | 1 | Target ready strobe |
| status_load | output | 1 | new_status is to be loaded (returns only) |
| next_pc | output | 32 | Computed next PC |
| new_status | output | 32 | Restored status word |
| saved_pc | output | 32 | Call-table saved PC |
| saved_status | output | 32 | Call-table saved status |

## Verification
The assertions check the handshake on every cycle:
- request and address hold while busy;
- saved state is frozen while busy;
- done follows read-valid and single-cycle returns;
- bit 0 of a restored PC is clear;
- the saved PC capture on a call.

Only the bench's sweeps can show that targets are arithmetically correct. The sweeps cover the table arithmetic over every call index, positive and negative switch offsets, the write mask on call-table return, and the exception-pair priority across all four status-bit combinations.

// File: rtl/tbl_xfer_unit.sv
module tbl_xfer_unit #(
  parameter int AW     = 32,
  parameter int IW     = 6,
  parameter int HW     = 16,
  parameter int SW     = 32,
  parameter int EP_BIT = 6,
  parameter int NP_BIT = 7,
  parameter logic [SW-1:0] WMASK = 32'h0000_00FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] tbase,
  input  logic [IW-1:0] call_idx,
  input  logic [AW-1:0] sw_idx,
  input  logic [SW-1:0] status_in,
  input  logic [AW-1:0] epc_in,
  input  logic [SW-1:0] estat_in,
  input  logic [AW-1:0] fepc_in,
  input  logic [SW-1:0] fstat_in,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [HW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          status_load,
  output logic [AW-1:0] next_pc,
  output logic [SW-1:0] new_status,
  output logic [AW-1:0] saved_pc,
  output logic [SW-1:0] saved_status
);
  localparam logic [1:0] OP_CALL = 2'd0;
  localparam logic [1:0] OP_SWJ  = 2'd1;
  localparam logic [1:0] OP_CRET = 2'd2;
  localparam logic [1:0] OP_ERET = 2'd3;

  logic          busy_q, is_sw_q, done_q, sload_q;
  logic [AW-1:0] base_q, addr_q, npc_q, spc_q;
  logic [SW-1:0] nst_q, sst_q;

  wire          accept  = op_valid & ~busy_q;
  wire [AW-1:0] pc_inc  = cur_pc + AW'(2);
  wire [AW-1:0] tb_even = {tbase[AW-1:1], 1'b0};
  wire [AW-1:0] call_a  = tb_even + {{(AW-IW-1){1'b0}}, call_idx, 1'b0};
  wire [AW-1:0] sw_a    = pc_inc + {sw_idx[AW-2:0], 1'b0};
  wire [AW-1:0] call_off = {{(AW-HW){1'b0}}, mem_rdata[HW-1:1], 1'b0};
  wire [AW-1:0] sw_off   = {{(AW-HW-1){mem_rdata[HW-1]}}, mem_rdata, 1'b0};
  wire          use_fatal = ~status_in[EP_BIT] & status_in[NP_BIT];
  wire [AW-1:0] e_pc   = use_fatal ? fepc_in : epc_in;
  wire [SW-1:0] e_st   = use_fatal ? fstat_in : estat_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      is_sw_q <= 1'b0;
      done_q  <= 1'b0;
      sload_q <= 1'b0;
      base_q  <= '0;
      addr_q  <= '0;
      npc_q   <= '0;
      nst_q   <= '0;
      spc_q   <= '0;
      sst_q   <= '0;
    end else begin
      done_q  <= 1'b0;
      sload_q <= 1'b0;
      if (busy_q) begin
        if (mem_valid) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          npc_q  <= base_q + (is_sw_q ? sw_off : call_off);
        end
      end else if (accept) begin
        case (op_code)
          OP_CALL: begin
            spc_q   <= pc_inc;
            sst_q   <= status_in;
            base_q  <= tb_even;
            addr_q  <= call_a;
            is_sw_q <= 1'b0;
            busy_q  <= 1'b1;
          end
          OP_SWJ: begin
            base_q  <= pc_inc;
            addr_q  <= sw_a;
            is_sw_q <= 1'b1;
            busy_q  <= 1'b1;
          end
          OP_CRET: begin
            npc_q   <= {spc_q[AW-1:1], 1'b0};
            nst_q   <= sst_q & WMASK;
            done_q  <= 1'b1;
            sload_q <= 1'b1;
          end
          OP_ERET: begin
            npc_q   <= {e_pc[AW-1:1], 1'b0};
            nst_q   <= e_st;
            done_q  <= 1'b1;
            sload_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign busy         = busy_q;
  assign mem_req      = busy_q;
  assign mem_addr     = addr_q;
  assign done         = done_q;
  assign status_load  = sload_q;
  assign next_pc      = npc_q;
  assign new_status   = nst_q;
  assign saved_pc     = spc_q;
  assign saved_status = sst_q;
endmodule

module tbl_xfer_unit_chk #(
  parameter int AW = 32,
  parameter int SW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [1:0]    op_code,
  input logic [AW-1:0] cur_pc,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_valid,
  input logic          busy,
  input logic          done,
  input logic          status_load,
  input logic [AW-1:0] next_pc,
  input logic [AW-1:0] saved_pc,
  input logic [SW-1:0] saved_status
);
  AST_CALL_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !busy && op_code == 2'd0 |=> saved_pc == $past(cur_pc) + AW'(2)); // R1
  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_valid |=> done && !busy && !status_load); // R3
  AST_RESTORED_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    status_load |-> next_pc[0] == 1'b0); // R9
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_valid |=> busy && mem_req && $stable(mem_addr)); // R10
  AST_SAVED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(saved_pc) && $stable(saved_status)); // R10
  AST_REQ_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req == busy); // R10
  AST_RET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !busy && op_code[1] |=> done && status_load && !busy && !mem_req); // R11
endmodule

bind tbl_xfer_unit tbl_xfer_unit_chk #(.AW(AW), .SW(SW)) chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .cur_pc(cur_pc), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_valid(mem_valid), .busy(busy), .done(done),
  .status_load(status_load), .next_pc(next_pc),
  .saved_pc(saved_pc), .saved_status(saved_status)
);

// File: tb/tbl_xfer_unit_test.sv
module tbl_xfer_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'h0000_00FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = '0;
  logic [31:0] cur_pc = '0, tbase = '0, sw_idx = '0, status_in = '0;
  logic [5:0]  call_idx = '0;
  logic [31:0] epc_in = '0, estat_in = '0, fepc_in = '0, fstat_in = '0;
  logic        mem_valid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        mem_req, busy, done, status_load;
  logic [31:0] mem_addr, next_pc, new_status, saved_pc, saved_status;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbl_xfer_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .cur_pc(cur_pc), .tbase(tbase), .call_idx(call_idx), .sw_idx(sw_idx),
    .status_in(status_in), .epc_in(epc_in), .estat_in(estat_in),
    .fepc_in(fepc_in), .fstat_in(fstat_in), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .status_load(status_load), .next_pc(next_pc),
    .new_status(new_status), .saved_pc(saved_pc), .saved_status(saved_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_tbl(input logic [1:0] op, input logic [31:0] pc, input logic [31:0] tb,
                         input logic [5:0] ci, input logic [31:0] swi, input logic [31:0] st,
                         input logic [15:0] rd, input int lat,
                         input logic [31:0] exp_addr, input logic [31:0] exp_pc);
    logic [31:0] sp, ss;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; cur_pc = pc; tbase = tb; call_idx = ci;
    sw_idx = swi; status_in = st;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R10 busy after issue", {31'b0, busy}, 32'd1);
    chk("R10 mem_req after issue", {31'b0, mem_req}, 32'd1);
    chk(op == 2'd0 ? "R2 call address" : "R4 switch address", mem_addr, exp_addr);
    if (op == 2'd0) begin
      chk("R1 saved_pc", saved_pc, pc + 32'd2);
      chk("R1 saved_status", saved_status, st);
    end
    sp = saved_pc; ss = saved_status;
    for (int k = 0; k < lat; k++) begin
      op_valid = 1'b1; op_code = 2'(k); cur_pc = 32'hDEAD_0000; status_in = 32'h0;
      @(negedge clk);
      chk("R10 ignored op no done", {31'b0, done}, 32'd0);
      chk("R10 busy held", {31'b0, busy}, 32'd1);
      chk("R10 addr stable", mem_addr, exp_addr);
      chk("R10 saved_pc frozen", saved_pc, sp);
      chk("R10 saved_status frozen", saved_status, ss);
    end
    op_valid = 1'b0;
    mem_valid = 1'b1; mem_rdata = rd;
    @(negedge clk);
    mem_valid = 1'b0;
    chk("R3 done after read", {31'b0, done}, 32'd1);
    chk("R3 busy cleared", {31'b0, busy}, 32'd0);
    chk(op == 2'd0 ? "R3 call target" : "R5 switch target", next_pc, exp_pc);
    @(negedge clk);
    chk("R3 done single pulse", {31'b0, done}, 32'd0);
  endtask

  task automatic run_ret(input logic [1:0] op, input logic [31:0] st,
                         input logic [31:0] exp_pc, input logic [31:0] exp_st, input string req);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; status_in = st;
    @(negedge clk);
    op_valid = 1'b0;
    chk({req, " pc"}, next_pc, exp_pc);
    chk({req, " status"}, new_status, exp_st);
    chk("R9 restored pc even", {31'b0, next_pc[0]}, 32'd0);
    chk("R11 done", {31'b0, done}, 32'd1);
    chk("R11 status_load", {31'b0, status_load}, 32'd1);
    chk("R11 no mem_req", {31'b0, mem_req}, 32'd0);
    chk("R11 not busy", {31'b0, busy}, 32'd0);
    @(negedge clk);
    chk("R11 done one cycle", {30'b0, done, status_load}, 32'd0);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset busy", {31'b0, busy}, 32'd0);
    chk("R10 reset mem_req", {31'b0, mem_req}, 32'd0);
    chk("R11 reset done", {31'b0, done}, 32'd0);
    chk("R1 reset saved_pc", saved_pc, 32'd0);

    // R2 R3: every call index, odd and even bases, varying read latency
    for (int i = 0; i < 64; i++) begin
      logic [31:0] tb, pc, be;
      logic [15:0] rd;
      tb = (i % 2 == 1) ? 32'h0010_0001 + 32'(i) * 32'd256 : 32'h0020_4000 + 32'(i) * 32'd64;
      pc = 32'h0000_1000 + 32'(i) * 32'd4;
      rd = 16'(i * 1237 + 5);
      be = {tb[31:1], 1'b0};
      run_tbl(2'd0, pc, tb, 6'(i), 32'h0, 32'hA500_0000 + 32'(i), rd, i % 3,
              be + 32'(i) * 32'd2, be + {16'h0, rd[15:1], 1'b0});
    end

    // R4 R5: positive and negative indexes, signed offsets
    for (int k = 0; k < 32; k++) begin
      logic [31:0] swi, pc, ex;
      logic [15:0] rd;
      swi = (k < 16) ? 32'(k) : -32'(k - 15);
      pc = 32'h0008_0000 + 32'(k) * 32'd2;
      rd = (k % 2 == 0) ? 16'(k * 300) : -16'(k * 77);
      ex = pc + 32'd2 + ({{16{rd[15]}}, rd} << 1);
      run_tbl(2'd1, pc, 32'h0, 6'd0, swi, 32'h0, rd, k % 2,
              pc + 32'd2 + (swi << 1), ex);
    end

    // R6: call-table return after a call with odd PC, with masked status
    for (int j = 0; j < 4; j++) begin
      logic [31:0] pc, st;
      pc = 32'h0000_3001 + 32'(j) * 32'd6;
      st = 32'hFFFF_AB00 + 32'(j * 37);
      run_tbl(2'd0, pc, 32'h100, 6'(j), 32'h0, st, 16'h0040, 0,
              32'h100 + 32'(j) * 32'd2, 32'h140);
      run_ret(2'd2, 32'h0, (pc + 32'd2) & 32'hFFFF_FFFE, st & MASK, "R6 call-table return");
    end

    // R7 R8: all four EP/NP combinations (bits 6 and 7)
    epc_in = 32'h0000_5555; estat_in = 32'h1234_0020;
    fepc_in = 32'h0000_7777; fstat_in = 32'h8765_0080;
    run_ret(2'd3, 32'h0000_0040, 32'h0000_5554, 32'h1234_0020, "R7 EP only");
    run_ret(2'd3, 32'h0000_00C0, 32'h0000_5554, 32'h1234_0020, "R7 EP and NP");
    run_ret(2'd3, 32'h0000_0080, 32'h0000_7776, 32'h8765_0080, "R8 NP only");
    run_ret(2'd3, 32'hFFFF_FF3F, 32'h0000_5554, 32'h1234_0020, "R8 neither");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule